// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block watches the command stream that a memory controller sends to a multi-bank SDRAM. It follows each bank through four states (idle, opening, open, closing) and judges each command as it arrives. A command is legal only if it suits the addressed bank's state and the row timings have elapsed. The guard enforces activate-to-column delay, minimum row-open time, precharge recovery, refresh recovery and a mode-set recovery. Every limit is a whole number of clock cycles, set by a parameter.

Commands enter on a `cmd_valid` qualifier with no ready signal. The guard never stalls the source, and each valid cycle is judged on its own. A legal command updates the bank model. An illegal one leaves the model untouched and raises a one-cycle violation flag with a reason code. Both results appear on registered outputs in the cycle after the command. The bank model is visible at all times as a packed 2-bit state per bank.

Top module: `bank_guard`

## Requirements
- R1: After reset every bank reads idle (state code 0) and both `cmd_ok` and `viol` are low. The per-bank state codes are: 0 idle, 1 opening, 2 open, 3 closing. Bank b occupies `bank_state[2b+1:2b]`.
- R2: Activate (op 1) is legal only on an idle bank. Activate on an opening or open bank is rejected with code 2 (wrong bank state).
- R3: Read (op 2), write (op 3) and burst stop (op 4) need the addressed bank to be open. On an idle or closing bank they get code 2. Issued fewer than T_RCD cycles after that bank's activate, they get code 3. At exactly T_RCD cycles they are accepted.
- R4: While one bank waits out its activate delay, commands to other banks are judged only on their own bank's state.
- R5: Precharge (op 5) needs an open bank, otherwise code 2. Issued fewer than T_RAS cycles after the activate, it gets code 4. Once accepted, the bank closes. An activate to that bank within T_RP cycles gets code 5, and at T_RP cycles it is accepted.
- R6: Precharge-all (op 6) is rejected with code 4 if any opening or open bank is still within T_RAS. Otherwise it closes every open bank at once. Banks that are idle or already closing are left as they are.
- R7: Auto refresh (op 7) and mode load (op 8) are legal only when every bank is idle or has finished its precharge recovery. Otherwise they get code 6.
- R8: After an accepted refresh, any command other than no-op within T_RFC cycles gets code 1. After an accepted mode load, the same holds for T_MRD cycles. Code 1 takes precedence over every other reason.
- R9: A no-op (op 0) is always legal, including during refresh or mode-set recovery.
- R10: A rejected command changes no bank state. In the cycle after it, `viol` is high for one cycle, `viol_code` holds the reason and `cmd_ok` is low. In the cycle after an accepted command, `cmd_ok` is high, `viol` is low and `viol_code` is 0.
- R11: Opcodes 9 to 15 are rejected with code 7.
- R12: A cycle with `cmd_valid` low has no effect on any bank. In the following cycle, both `cmd_ok` and `viol` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command opcode (0 to 8 defined) |
| cmd_bank | input | BANK_BITS | Addressed bank |
| bank_state | output | 2*2**BANK_BITS | Packed per-bank state codes |
| cmd_ok | output | 1 | Previous cycle's command was legal |
| viol | output | 1 | Previous cycle's command was rejected |
| viol_code | output | 3 | Rejection reason (0 when none) |

## Verification
The main stream interleaves activates, column commands and precharges across several banks, so a per-bank timer cannot be mistaken for a shared one. Commands are placed one cycle before and exactly at each limit (T_RCD, T_RAS, T_RP, T_RFC, T_MRD), which tells an off-by-one apart from a correct boundary. Refresh and mode load are tried with one bank open, one bank mid-recovery and all banks idle, which separates the global idle condition from the per-bank checks. Rejected precharge-all and cycles with `cmd_valid` low are followed by a read of the bank states, to show that nothing moved.

// File: rtl/bank_guard_pkg.sv
`timescale 1ns/1ps
package bank_guard_pkg;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ACT  = 4'd1;
  localparam logic [3:0] OP_RD   = 4'd2;
  localparam logic [3:0] OP_WR   = 4'd3;
  localparam logic [3:0] OP_BST  = 4'd4;
  localparam logic [3:0] OP_PRE  = 4'd5;
  localparam logic [3:0] OP_PREA = 4'd6;
  localparam logic [3:0] OP_REF  = 4'd7;
  localparam logic [3:0] OP_LMR  = 4'd8;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPENING = 2'd1,
    BK_OPEN    = 2'd2,
    BK_CLOSING = 2'd3
  } bank_st_e;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_BUSY     = 3'd1,
    V_STATE    = 3'd2,
    V_TRCD     = 3'd3,
    V_TRAS     = 3'd4,
    V_TRP      = 3'd5,
    V_NOT_IDLE = 3'd6,
    V_OPCODE   = 3'd7
  } viol_e;

endpackage

// File: rtl/bank_tracker.sv
`timescale 1ns/1ps
module bank_tracker
  import bank_guard_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     open_go,
  input  logic     close_go,
  output bank_st_e st,
  output logic     col_ready,
  output logic     is_open,
  output logic     ras_done,
  output logic     idle_ready
);

  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_RAS + 1);

  logic [TW-1:0] phase_cnt;   // remaining cycles of tRCD or tRP
  logic [RW-1:0] ras_cnt;     // remaining cycles of tRAS

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BK_IDLE;
      phase_cnt <= '0;
      ras_cnt   <= '0;
    end else if (open_go) begin
      st        <= BK_OPENING;
      phase_cnt <= TW'(T_RCD - 1);
      ras_cnt   <= RW'(T_RAS - 1);
    end else begin
      if (close_go) begin
        st        <= BK_CLOSING;
        phase_cnt <= TW'(T_RP - 1);
      end else begin
        if (phase_cnt != '0) phase_cnt <= phase_cnt - 1'b1;
        if (st == BK_OPENING && phase_cnt == '0) st <= BK_OPEN;
        if (st == BK_CLOSING && phase_cnt == '0) st <= BK_IDLE;
      end
      if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
    end
  end

  assign is_open    = (st == BK_OPENING) || (st == BK_OPEN);
  assign col_ready  = (st == BK_OPEN) || (st == BK_OPENING && phase_cnt == '0);
  assign ras_done   = (ras_cnt == '0);
  assign idle_ready = (st == BK_IDLE) || (st == BK_CLOSING && phase_cnt == '0);

endmodule

// File: rtl/busy_timer.sv
`timescale 1ns/1ps
module busy_timer #(
  parameter int T_RFC = 8,
  parameter int T_MRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_go,
  input  logic mrs_go,
  output logic busy
);

  localparam int LMAX = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (ref_go)          cnt <= CW'(T_RFC - 1);
    else if (mrs_go)          cnt <= CW'(T_MRD - 1);
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/cmd_judge.sv
`timescale 1ns/1ps
module cmd_judge
  import bank_guard_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input  logic                 valid,
  input  logic [3:0]           op,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 busy,
  input  logic [NB-1:0]        is_open,
  input  logic [NB-1:0]        col_ready,
  input  logic [NB-1:0]        ras_done,
  input  logic [NB-1:0]        idle_ready,
  output logic                 legal,
  output viol_e                code,
  output logic [NB-1:0]        open_go,
  output logic [NB-1:0]        close_go,
  output logic                 ref_go,
  output logic                 mrs_go
);

  logic [NB-1:0] sel;
  assign sel = NB'(1) << bank;

  always_comb begin
    code = V_NONE;
    if (valid && op != OP_NOP) begin
      if (busy) begin
        code = V_BUSY;
      end else begin
        case (op)
          OP_ACT: begin
            if (is_open[bank])          code = V_STATE;
            else if (!idle_ready[bank]) code = V_TRP;
          end
          OP_RD, OP_WR, OP_BST: begin
            if (!is_open[bank])         code = V_STATE;
            else if (!col_ready[bank])  code = V_TRCD;
          end
          OP_PRE: begin
            if (!is_open[bank])         code = V_STATE;
            else if (!ras_done[bank])   code = V_TRAS;
          end
          OP_PREA: begin
            if ((is_open & ~ras_done) != '0) code = V_TRAS;
          end
          OP_REF, OP_LMR: begin
            if (!(&idle_ready))         code = V_NOT_IDLE;
          end
          default:                      code = V_OPCODE;
        endcase
      end
    end
  end

  assign legal = valid && (code == V_NONE);

  always_comb begin
    open_go  = '0;
    close_go = '0;
    if (legal && op == OP_ACT)  open_go  = sel;
    if (legal && op == OP_PRE)  close_go = sel;
    if (legal && op == OP_PREA) close_go = is_open;
  end

  assign ref_go = legal && (op == OP_REF);
  assign mrs_go = legal && (op == OP_LMR);

endmodule

// File: rtl/bank_guard.sv
`timescale 1ns/1ps
module bank_guard
  import bank_guard_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [3:0]                   cmd_op,
  input  logic [BANK_BITS-1:0]         cmd_bank,
  output logic [2*(1<<BANK_BITS)-1:0]  bank_state,
  output logic                         cmd_ok,
  output logic                         viol,
  output logic [2:0]                   viol_code
);

  localparam int NB = 1 << BANK_BITS;

  logic [NB-1:0] is_open, col_ready, ras_done, idle_ready;
  logic [NB-1:0] open_go, close_go;
  logic          ref_go, mrs_go, busy, legal;
  viol_e         code;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_st_e st_b;
    bank_tracker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .open_go(open_go[b]), .close_go(close_go[b]),
      .st(st_b), .col_ready(col_ready[b]), .is_open(is_open[b]),
      .ras_done(ras_done[b]), .idle_ready(idle_ready[b])
    );
    assign bank_state[2*b +: 2] = st_b;
  end

  busy_timer #(.T_RFC(T_RFC), .T_MRD(T_MRD)) u_busy (
    .clk(clk), .rst_n(rst_n), .ref_go(ref_go), .mrs_go(mrs_go), .busy(busy)
  );

  cmd_judge #(.BANK_BITS(BANK_BITS)) u_judge (
    .valid(cmd_valid), .op(cmd_op), .bank(cmd_bank), .busy(busy),
    .is_open(is_open), .col_ready(col_ready), .ras_done(ras_done),
    .idle_ready(idle_ready), .legal(legal), .code(code),
    .open_go(open_go), .close_go(close_go), .ref_go(ref_go), .mrs_go(mrs_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ok    <= 1'b0;
      viol      <= 1'b0;
      viol_code <= 3'd0;
    end else begin
      cmd_ok    <= legal;
      viol      <= cmd_valid && !legal;
      viol_code <= code;
    end
  end

endmodule

// File: rtl/bank_guard_checker.sv
`timescale 1ns/1ps
module bank_guard_checker
  import bank_guard_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [3:0]           cmd_op,
  input logic [BANK_BITS-1:0] cmd_bank,
  input logic [2*NB-1:0]      bank_state,
  input logic                 cmd_ok,
  input logic                 viol,
  input logic [2:0]           viol_code
);

  logic none_open;
  always_comb begin
    none_open = 1'b1;
    for (int i = 0; i < NB; i++)
      if (bank_state[2*i +: 2] == 2'd1 || bank_state[2*i +: 2] == 2'd2) none_open = 1'b0;
  end

  assert_nop_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_NOP) |=> cmd_ok);

  assert_code_on_viol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0));

  assert_quiet_when_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_ok && !viol));

  assert_refresh_all_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && ($past(cmd_op) == OP_REF || $past(cmd_op) == OP_LMR)) |-> $past(none_open));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    assert_open_needs_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_state[2*b +: 2] == 2'd1) |->
        (cmd_ok && $past(cmd_op) == OP_ACT && $past(cmd_bank) == BANK_BITS'(b)));

    assert_close_needs_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_state[2*b +: 2] == 2'd3) |->
        (cmd_ok && ($past(cmd_op) == OP_PRE || $past(cmd_op) == OP_PREA)));

    assert_col_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ok && ($past(cmd_op) == OP_RD || $past(cmd_op) == OP_WR)
              && $past(cmd_bank) == BANK_BITS'(b)) |->
        ($past(bank_state[2*b +: 2]) == 2'd1 || $past(bank_state[2*b +: 2]) == 2'd2));
  end

endmodule

bind bank_guard bank_guard_checker #(.BANK_BITS(BANK_BITS)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .bank_state(bank_state), .cmd_ok(cmd_ok),
  .viol(viol), .viol_code(viol_code)
);

// File: tb/bank_guard_test.sv
`timescale 1ns/1ps
module bank_guard_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [7:0] bank_state;
  logic       cmd_ok, viol;
  logic [2:0] viol_code;

  always #2 clk = ~clk;  // 250 MHz

  bank_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .bank_state(bank_state), .cmd_ok(cmd_ok),
    .viol(viol), .viol_code(viol_code)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // {op[3:0], bank[1:0], ok, code[2:0]}; defaults tRCD=3 tRAS=6 tRP=3 tRFC=8 tMRD=2
  localparam int NV = 34;
  localparam logic [9:0] VEC [NV] = '{
    {4'd1, 2'd0, 1'b1, 3'd0},  //  0 ACT b0            R2
    {4'd2, 2'd0, 1'b0, 3'd3},  //  1 RD b0 early       R3
    {4'd1, 2'd1, 1'b1, 3'd0},  //  2 ACT b1 in tRCD    R4
    {4'd2, 2'd0, 1'b1, 3'd0},  //  3 RD b0 at tRCD     R3
    {4'd1, 2'd0, 1'b0, 3'd2},  //  4 ACT open b0       R2
    {4'd5, 2'd0, 1'b0, 3'd4},  //  5 PRE b0 early      R5
    {4'd5, 2'd0, 1'b1, 3'd0},  //  6 PRE b0 at tRAS    R5
    {4'd3, 2'd1, 1'b1, 3'd0},  //  7 WR b1             R4
    {4'd1, 2'd0, 1'b0, 3'd5},  //  8 ACT b0 in tRP     R5
    {4'd7, 2'd0, 1'b0, 3'd6},  //  9 REF, b1 open      R7
    {4'd5, 2'd1, 1'b1, 3'd0},  // 10 PRE b1            R5
    {4'd3, 2'd0, 1'b0, 3'd2},  // 11 WR idle b0        R3
    {4'd0, 2'd0, 1'b1, 3'd0},  // 12 NOP               R9
    {4'd7, 2'd0, 1'b1, 3'd0},  // 13 REF all idle      R7
    {4'd0, 2'd0, 1'b1, 3'd0},  // 14 NOP in tRFC       R9
    {4'd1, 2'd2, 1'b0, 3'd1},  // 15 ACT in tRFC       R8
    {4'd0, 2'd0, 1'b1, 3'd0},  // 16 NOP               R9
    {4'd0, 2'd0, 1'b1, 3'd0},  // 17
    {4'd0, 2'd0, 1'b1, 3'd0},  // 18
    {4'd0, 2'd0, 1'b1, 3'd0},  // 19
    {4'd1, 2'd2, 1'b0, 3'd1},  // 20 ACT last busy     R8
    {4'd1, 2'd2, 1'b1, 3'd0},  // 21 ACT at tRFC       R8
    {4'd8, 2'd0, 1'b0, 3'd6},  // 22 LMR, b2 opening   R7
    {4'd4, 2'd2, 1'b0, 3'd3},  // 23 BST early         R3
    {4'd4, 2'd2, 1'b1, 3'd0},  // 24 BST at tRCD       R3
    {4'd15,2'd0, 1'b0, 3'd7},  // 25 bad opcode        R11
    {4'd6, 2'd0, 1'b0, 3'd4},  // 26 PREA early        R6
    {4'd6, 2'd0, 1'b1, 3'd0},  // 27 PREA at tRAS      R6
    {4'd4, 2'd2, 1'b0, 3'd2},  // 28 BST closing b2    R3
    {4'd8, 2'd0, 1'b0, 3'd6},  // 29 LMR in tRP        R7
    {4'd8, 2'd0, 1'b1, 3'd0},  // 30 LMR all idle      R7
    {4'd2, 2'd3, 1'b0, 3'd1},  // 31 RD in tMRD        R8
    {4'd1, 2'd3, 1'b1, 3'd0},  // 32 ACT at tMRD       R8
    {4'd6, 2'd0, 1'b0, 3'd4}   // 33 PREA, b3 young    R6
  };

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_bank = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset bank_state", bank_state, 0);
    chk("R1 reset cmd_ok", cmd_ok, 0);
    chk("R1 reset viol", viol, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      cmd_valid = 1'b1;
      cmd_op    = VEC[i][9:6];
      cmd_bank  = VEC[i][5:4];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 vec %0d cmd_ok", i), cmd_ok, VEC[i][3]);
      chk($sformatf("R10 vec %0d viol", i), viol, !VEC[i][3]);
      chk($sformatf("R10 vec %0d viol_code", i), viol_code, VEC[i][2:0]);
    end

    // R10: rejected precharge-all left bank 3 opening, others idle
    chk("R10 state after rejected PREA", bank_state, 8'h40);

    // R12: activate with valid low has no effect
    cmd_valid = 1'b0; cmd_op = 4'd1; cmd_bank = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R12 cmd_ok with valid low", cmd_ok, 0);
    chk("R12 viol with valid low", viol, 0);
    chk("R12 bank 0 still idle", bank_state[1:0], 0);

    // R1: reset in mid-run clears an opening bank
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset bank_state", bank_state, 0);
    chk("R1 mid-run reset viol_code", viol_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule